// File: doc/BRIEF.md
# Device Directory Table Walker

This block finds where a device's context record lives in memory, given the device's 24-bit identifier. The directory is a radix tree with one, two or three levels. Its top page is named by a root page number. Each non-leaf level holds 64-bit pointer entries. The walker fetches one pointer per non-leaf level over a request/response memory port whose latency may vary. It then returns either the byte address of the leaf context record or a fault code.

Two record layouts are supported: a base layout with 32-byte context records and an extended layout with 64-byte records. The layout changes how the identifier is cut into per-level indices, how many identifiers fit in one leaf page, and the stride between records. A walk starts on a one-cycle start pulse. It ends with a one-cycle done pulse that carries the address or the fault. Reading the context record itself is left to the requester.

Top module: `ddt_walker`

## Requirements
- R1: The mode input selects the depth: 2 gives one level, 3 gives two levels and 4 gives three levels. Any other mode value gives done one cycle after start, with fault code 1 and no memory request. Fault codes are: 0 none, 1 bad mode, 2 out of range, 3 invalid entry, 4 access error.
- R2: In base layout, the low level index is ID bits 6:0, the middle index is bits 15:7 and the top index is bits 23:16. An ID at or above 2^7 (one level) or 2^16 (two levels) gives done one cycle after start, with fault code 2 and no memory request.
- R3: In extended layout, the index fields are ID bits 5:0, 14:6 and 23:15. The range limits become 2^6 (one level) and 2^15 (two levels). Three-level walks accept every 24-bit ID.
- R4: The walk makes exactly depth-1 pointer fetches, highest level first. Each fetch reads from the current page base plus 8 times a 9-bit index, where the index is the ID shifted right by the split below that level. The first page base is the root page number shifted left by 12.
- R5: A fetched entry's bits 53:10 become bits 55:12 of the next page base. Entry bits 63:54 and 9:1 have no effect on the result.
- R6: If a fetched entry has bit 0 clear, the walk ends with fault code 3, and no further request is made.
- R7: If a response is flagged as an access error, the walk ends with fault code 4, whatever the returned data holds.
- R8: On success the fault is 0. The address is the final page base plus the low index times 32 (base layout) or times 64 (extended layout). On any fault the address output is zero.
- R9: done is a single-cycle pulse. busy is high from the cycle after an accepted start through the last waiting cycle, and low in the done cycle. Walks that end without a fetch never raise busy.
- R10: A start while busy is ignored and does not change the running walk's result.
- R11: A memory request keeps its valid flag and address unchanged until the memory accepts it with ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| mode | input | 4 | Directory depth selector |
| ext_fmt | input | 1 | 1 = extended record layout, 0 = base |
| root_ppn | input | 44 | Root page number |
| dev_id | input | 24 | Device identifier to look up |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | Fault code, valid with done |
| leaf_addr | output | 56 | Context record byte address, valid with done |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 56 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Response available |
| mem_rsp_data | input | 64 | Returned entry |
| mem_rsp_err | input | 1 | Response carries an access error |

## Verification
Two functions meet in one cycle when a fresh start arrives in the cycle where done reports the previous walk. The walker must then both report the old walk and accept the new one. The bench provokes this by raising start in the very cycle it sees done, across all modes and both layouts, mixing immediate faults with multi-level walks. It judges each walk in the chain by its own fault, address and fetch list. A second collision is a start during a running walk; the bench pokes the walker with a different mode and ID and checks that the first walk's result is unchanged.

// File: rtl/ddw_pkg.sv
package ddw_pkg;

  localparam int ID_BITS     = 24;
  localparam int IDX_W       = 9;
  localparam int PAGE_SHIFT  = 12;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_MODE    = 3'd1,
    FLT_RANGE   = 3'd2,
    FLT_INVALID = 3'd3,
    FLT_BUSERR  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } walk_st_e;

  // Number of low ID bits that index records within a leaf page.
  function automatic int low_bits(logic ext);
    return ext ? 6 : 7;
  endfunction

  // Byte stride of one context record, as a shift amount.
  function automatic int rec_shift(logic ext);
    return ext ? 6 : 5;
  endfunction

  // Cumulative ID bit count covered by levels 1..lvl.
  function automatic int split_at(logic ext, int lvl);
    case (lvl)
      1:       return low_bits(ext);
      2:       return low_bits(ext) + IDX_W;
      default: return ID_BITS;
    endcase
  endfunction

  // Tree depth for a mode value; 0 marks an unsupported mode.
  function automatic logic [1:0] depth_of(logic [3:0] m);
    case (m)
      4'd2:    return 2'd1;
      4'd3:    return 2'd2;
      4'd4:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddw_split.sv
module ddw_split
  import ddw_pkg::*;
#(
  parameter int ID_W = ID_BITS
) (
  input  logic [ID_W-1:0] dev_id,
  input  logic            ext,
  input  logic [1:0]      depth,
  input  logic [1:0]      level,
  output logic            out_of_range,
  output logic [IDX_W-1:0] nl_idx,
  output logic [PAGE_SHIFT-1:0] leaf_off
);

  logic [63:0] wide_id;
  logic [63:0] idx_full;
  logic [63:0] off_full;
  logic [63:0] low_mask;

  always_comb begin
    wide_id      = 64'(dev_id);
    out_of_range = (depth != 2'd0) &&
                   ((wide_id >> split_at(ext, int'(depth))) != 64'd0);
    idx_full     = (wide_id >> split_at(ext, int'(level))) & 64'h1FF;
    nl_idx       = idx_full[IDX_W-1:0];
    low_mask     = (64'd1 << low_bits(ext)) - 64'd1;
    off_full     = (wide_id & low_mask) << rec_shift(ext);
    leaf_off     = off_full[PAGE_SHIFT-1:0];
  end

endmodule

// File: rtl/ddw_entry.sv
module ddw_entry
  import ddw_pkg::*;
#(
  parameter int PA_W = 56,
  parameter int DW   = 64
) (
  input  logic [DW-1:0]   ent,
  output logic            ent_valid,
  output logic [PA_W-1:0] next_pa
);

  logic unused_ent_bits;

  assign ent_valid       = ent[0];
  assign next_pa         = {ent[PA_W-3:10], {PAGE_SHIFT{1'b0}}};
  assign unused_ent_bits = ^{ent[DW-1:PA_W-2], ent[9:1]};

endmodule

// File: rtl/ddt_walker.sv
module ddt_walker
  import ddw_pkg::*;
#(
  parameter int ID_W   = ID_BITS,
  parameter int PA_W   = 56,
  parameter int DW     = 64,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              ext_fmt,
  input  logic [PA_W-13:0]  root_ppn,
  input  logic [ID_W-1:0]   dev_id,
  output logic              busy,
  output logic              done,
  output logic [2:0]        fault,
  output logic [PA_W-1:0]   leaf_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              mem_rsp_err
);

  localparam int PPN_W = PA_W - PAGE_SHIFT;

  walk_st_e        state;
  logic [ID_W-1:0] id_q;
  logic            ext_q;
  logic [1:0]      step_q;
  logic [PA_W-1:0] page_q;
  logic            done_q;
  fault_e          fault_q;
  logic [PA_W-1:0] leaf_q;

  logic            idle;
  logic [1:0]      depth_in;
  logic [PA_W-1:0] root_pa;
  logic [ID_W-1:0] sel_id;
  logic            sel_ext;
  logic [1:0]      sel_depth;
  logic [1:0]      sel_level;
  logic            range_bad;
  logic [IDX_W-1:0] nl_idx;
  logic [PAGE_SHIFT-1:0] leaf_off;
  logic            ent_valid;
  logic [PA_W-1:0] next_pa;

  // Named events for the assertions
  logic ev_accept, ev_bad_mode, ev_range, ev_rsp;

  assign idle      = (state == ST_IDLE);
  assign depth_in  = depth_of(4'(mode));
  assign root_pa   = {root_ppn, {PAGE_SHIFT{1'b0}}};
  assign sel_id    = idle ? dev_id  : id_q;
  assign sel_ext   = idle ? ext_fmt : ext_q;
  assign sel_depth = idle ? depth_in : 2'd0;
  assign sel_level = idle ? (depth_in - 2'd1) : step_q;

  assign ev_accept   = start && idle;
  assign ev_bad_mode = ev_accept && (depth_in == 2'd0);
  assign ev_range    = ev_accept && !ev_bad_mode && range_bad;
  assign ev_rsp      = (state == ST_WAIT) && mem_rsp_valid;

  ddw_split #(.ID_W(ID_W)) i_split (
    .dev_id       (sel_id),
    .ext          (sel_ext),
    .depth        (sel_depth),
    .level        (sel_level),
    .out_of_range (range_bad),
    .nl_idx       (nl_idx),
    .leaf_off     (leaf_off)
  );

  ddw_entry #(.PA_W(PA_W), .DW(DW)) i_entry (
    .ent       (mem_rsp_data),
    .ent_valid (ent_valid),
    .next_pa   (next_pa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      id_q    <= '0;
      ext_q   <= 1'b0;
      step_q  <= 2'd0;
      page_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      leaf_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          id_q   <= dev_id;
          ext_q  <= ext_fmt;
          page_q <= root_pa;
          step_q <= depth_in - 2'd1;
          if (depth_in == 2'd0) begin
            done_q <= 1'b1; fault_q <= FLT_MODE;  leaf_q <= '0;
          end else if (range_bad) begin
            done_q <= 1'b1; fault_q <= FLT_RANGE; leaf_q <= '0;
          end else if (depth_in == 2'd1) begin
            done_q <= 1'b1; fault_q <= FLT_NONE;
            leaf_q <= {root_pa[PA_W-1:PAGE_SHIFT], leaf_off};
          end else begin
            state <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            done_q <= 1'b1; fault_q <= FLT_BUSERR;  leaf_q <= '0; state <= ST_IDLE;
          end else if (!ent_valid) begin
            done_q <= 1'b1; fault_q <= FLT_INVALID; leaf_q <= '0; state <= ST_IDLE;
          end else if (step_q == 2'd1) begin
            done_q <= 1'b1; fault_q <= FLT_NONE;
            leaf_q <= {next_pa[PA_W-1:PAGE_SHIFT], leaf_off};
            state  <= ST_IDLE;
          end else begin
            page_q <= next_pa;
            step_q <= step_q - 2'd1;
            state  <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = !idle;
  assign done          = done_q;
  assign fault         = fault_q;
  assign leaf_addr     = leaf_q;
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = page_q + {{(PA_W-IDX_W-3){1'b0}}, nl_idx, 3'b000};

  // Assertions
  assert_bad_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_mode |=> done && fault == FLT_MODE && !mem_req_valid);

  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range |=> done && fault == FLT_RANGE && !busy);

  assert_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp && !mem_rsp_err && !ent_valid |=> done && fault == FLT_INVALID && !mem_req_valid);

  assert_buserr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp && mem_rsp_err |=> done && fault == FLT_BUSERR);

  assert_leaf_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == FLT_NONE && !ext_q |-> leaf_addr[4:0] == 5'd0);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(id_q) && $stable(ext_q));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_no_req_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  logic unused_ppn_w;
  assign unused_ppn_w = (PPN_W > 0);

endmodule

// File: tb/test_ddt_walker.sv
`timescale 1ns/1ps
module test_ddt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        ext_fmt = 1'b0;
  logic [43:0] root_ppn = '0;
  logic [23:0] dev_id = '0;
  logic        busy, done;
  logic [2:0]  fault;
  logic [55:0] leaf_addr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;

  int errors = 0;
  int checks = 0;

  // memory model knobs
  logic       hole_en = 1'b0;
  logic [8:0] hole_idx = '0;
  logic       err_en = 1'b0;
  logic [8:0] err_idx = '0;
  logic [15:0] lfsr = 16'hACE1;
  int          req_cnt = 0;
  logic [55:0] req_log [0:3];
  logic [55:0] exp_addr [0:3];

  always #10 clk = ~clk;

  ddt_walker i_ddt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ext_fmt(ext_fmt),
    .root_ppn(root_ppn), .dev_id(dev_id), .busy(busy), .done(done),
    .fault(fault), .leaf_addr(leaf_addr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err)
  );

  function automatic logic [63:0] ent_of(logic [55:0] a);
    logic [43:0] p;
    p = {4'hA, a[42:3]} ^ 44'h0000F0F0F0F;
    return {10'h3FF, p, 9'h155, !(hole_en && a[11:3] == hole_idx)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    bit seen = 0, pending = 0;
    int wcnt = 0, rcnt = 0;
    logic [55:0] hold_a = '0, cap_a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (!rst_n) begin
        seen = 0; pending = 0; mem_req_ready = 1'b0;
      end else if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        pending = 1;
        rcnt = int'(lfsr[3:2]);
      end else if (pending) begin
        if (rcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = ent_of(cap_a);
          mem_rsp_err   = err_en && (cap_a[11:3] == err_idx);
          pending = 0;
        end else rcnt--;
      end else if (mem_req_valid) begin
        if (!seen) begin
          seen = 1; hold_a = mem_req_addr; wcnt = int'(lfsr[1:0]);
        end else begin
          chk(mem_req_addr == hold_a, "R11 request address held", 64'(mem_req_addr), 64'(hold_a));
        end
        if (wcnt == 0) begin
          mem_req_ready = 1'b1;
          cap_a = mem_req_addr;
          if (req_cnt < 4) req_log[req_cnt] = mem_req_addr;
          req_cnt++;
          seen = 0;
        end else wcnt--;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
    end
  end

  task automatic expect_walk(input logic [3:0] m, input logic e, input logic [43:0] root,
                             input logic [23:0] id, output logic [2:0] f,
                             output logic [55:0] leaf, output int nreq);
    int lo, lv, width;
    logic [55:0] page, a;
    logic [63:0] ent;
    logic [31:0] idx;
    nreq = 0; leaf = '0;
    lo = e ? 6 : 7;
    if (m < 4'd2 || m > 4'd4) begin f = 3'd1; return; end
    lv = int'(m) - 1;
    width = (lv == 1) ? lo : (lv == 2) ? lo + 9 : 24;
    if (32'(id) >= (32'd1 << width)) begin f = 3'd2; return; end
    page = {root, 12'h000};
    for (int s = lv - 1; s >= 1; s--) begin
      idx = (s == 2) ? (32'(id) >> (lo + 9)) : (32'(id) >> lo);
      idx = idx & 32'h1FF;
      a = page + 56'(idx) * 56'd8;
      exp_addr[nreq] = a;
      nreq++;
      if (err_en && a[11:3] == err_idx) begin f = 3'd4; return; end
      ent = ent_of(a);
      if (!ent[0]) begin f = 3'd3; return; end
      page = {ent[53:10], 12'h000};
    end
    leaf = page + 56'(32'(id) & ((32'd1 << lo) - 1)) * (e ? 56'd64 : 56'd32);
    f = 3'd0;
  endtask

  function automatic string tag_of(logic [2:0] f, logic e, int nreq);
    case (f)
      3'd1: return "R1 bad mode";
      3'd2: return e ? "R3 range ext" : "R2 range base";
      3'd3: return "R6 invalid entry";
      3'd4: return "R7 access error";
      default: return (nreq > 0) ? (e ? "R8 R5 R3 leaf" : "R8 R5 R2 leaf") : "R8 leaf";
    endcase
  endfunction

  task automatic run_walk(input logic [3:0] m, input logic e, input logic [43:0] root,
                          input logic [23:0] id, input bit chain, input bit poke, input bit settle);
    logic [2:0] ef; logic [55:0] el; int nreq, n;
    string t;
    expect_walk(m, e, root, id, ef, el, nreq);
    t = tag_of(ef, e, nreq);
    if (!chain) @(negedge clk);
    req_cnt = 0;
    mode = m; ext_fmt = e; root_ppn = root; dev_id = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nreq > 0) begin
      chk(busy == 1'b1 && done == 1'b0, "R9 busy during walk", 64'(busy), 64'd1);
      if (poke) begin
        mode = 4'd4; ext_fmt = ~e; dev_id = ~id; root_ppn = ~root; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R9 done seen", 64'(done), 64'd1);
    chk(fault == ef, t, 64'(fault), 64'(ef));
    chk(leaf_addr == el, t, 64'(leaf_addr), 64'(el));
    if (poke && nreq > 0)
      chk(fault == ef && leaf_addr == el, "R10 start while busy ignored", 64'(leaf_addr), 64'(el));
    chk(busy == 1'b0, "R9 busy low in done cycle", 64'(busy), 64'd0);
    chk(req_cnt == nreq, "R4 fetch count", 64'(req_cnt), 64'(nreq));
    for (int i = 0; i < nreq && i < req_cnt; i++)
      chk(req_log[i] == exp_addr[i], "R4 fetch address", 64'(req_log[i]), 64'(exp_addr[i]));
    if (settle) begin
      @(negedge clk);
      chk(done == 1'b0, "R9 done single pulse", 64'(done), 64'd0);
      chk(mem_req_valid == 1'b0, "R11 no request when idle", 64'(mem_req_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] ids [0:7];
    int lo;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R11 reset request", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        lo = (e != 0) ? 6 : 7;
        ids[0] = 24'd0;
        ids[1] = 24'd1;
        ids[2] = 24'((1 << lo) - 1);
        ids[3] = 24'(1 << lo);
        ids[4] = 24'((1 << (lo + 9)) - 1);
        ids[5] = 24'(1 << (lo + 9));
        ids[6] = 24'hFFFFFF;
        ids[7] = 24'h9C35A7;
        for (int k = 0; k < 8; k++)
          run_walk(4'(m), e[0], 44'h0123456789 + 44'(k * 4099 + m * 77), ids[k],
                   (k % 3) == 1, k == 6, (k % 3) == 2);
      end
    end

    // invalid entries at various tree positions
    hole_en = 1'b1;
    for (int e = 0; e < 2; e++) begin
      lo = (e != 0) ? 6 : 7;
      hole_idx = 9'((24'h9C35A7 >> (lo + 9)) & 24'h1FF);
      run_walk(4'd4, e[0], 44'h00ABCDE12, 24'h9C35A7, 0, 0, 1);
      hole_idx = 9'((24'h9C35A7 >> lo) & 24'h1FF);
      run_walk(4'd4, e[0], 44'h00ABCDE12, 24'h9C35A7, 0, 0, 1);
      run_walk(4'd3, e[0], 44'h0000FFFF1, 24'h001234 & 24'((1 << (lo + 9)) - 1), 1, 0, 1);
    end
    hole_en = 1'b0;

    // access errors, including on an entry whose valid bit is set
    err_en = 1'b1;
    for (int e = 0; e < 2; e++) begin
      lo = (e != 0) ? 6 : 7;
      err_idx = 9'((24'h5EED42 >> (lo + 9)) & 24'h1FF);
      run_walk(4'd4, e[0], 44'h0FEDCBA98, 24'h5EED42, 0, 0, 0);
      err_idx = 9'((24'h5EED42 >> lo) & 24'h1FF);
      run_walk(4'd4, e[0], 44'h0FEDCBA98, 24'h5EED42, 1, 0, 1);
    end
    err_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule